// File: doc/BRIEF.md
# Radix-8 Booth multiplier for residues modulo 2^N-1

This block multiplies two N-bit residues and returns their product reduced modulo 2^N-1. It is one channel of a residue-number datapath. All operands are plain unsigned residues, and the all-ones pattern is accepted as a second way of writing zero.

The multiplier operand is recoded into signed radix-8 digits in the range -4..+4, one digit for each group of three bits. The recoding wraps cyclically, so the bit below the lowest digit is the top bit of the padded operand. Each digit selects 0, A, 2A, 3A or 4A, rotated into place. A negative digit complements the selection.

The odd multiple 3A comes from short ripple adders of width K. These adders never pass a carry to each other. Each carry they produce is kept as a separate vector and rotated to the start of the next segment. All selected vectors are compressed by a tree of carry-save rows. Every row sends its top carry back into bit 0. A Sklansky prefix adder with end-around carry gives the final sum, which is then normalised.

Data enters and leaves through valid/ready handshakes:
- With `OUT_REG=1`, one output register sits between the two handshakes. An input is taken when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the register is empty or is being drained in that same cycle. A held result and its `out_valid` do not change while `out_ready` is low.
- With `OUT_REG=0`, the path is purely combinational. Valid and ready pass straight through.

Top module: `mod_mul_booth8`

## Requirements
- R1: With valid input pairs `in_a`, `in_b` in 0..2^N-1, the delivered `out_p` equals (in_a*in_b) mod (2^N-1).
- R2: A product that is congruent to zero is always presented as all zeros, never as all ones. This includes inputs that are all ones.
- R3: The result is independent of the segment width K. It is correct when K does not divide N.
- R4: The result is correct when N is a multiple of 3 and K exceeds N. In this case the lowest digit takes its lower bit from the operand's top bit.
- R5: With `OUT_REG=1`, an input accepted at a rising edge appears on `out_p` with `out_valid` high right after that edge.
- R6: With `OUT_REG=1`, while `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_p` keeps its value.
- R7: With `OUT_REG=1`, `in_ready` equals (not `out_valid`) or `out_ready`.
- R8: With `OUT_REG=0`, `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and `out_p` shows the product in the same cycle.
- R9: During and right after the active-low asynchronous reset `rst_n`, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take the operand pair |
| in_a | input | N | Multiplicand residue |
| in_b | input | N | Multiplier residue (Booth recoded) |
| out_valid | output | 1 | Product available |
| out_ready | input | 1 | Consumer takes the product |
| out_p | output | N | Normalised product modulo 2^N-1 |

## Verification
With the output register present, a pair accepted at a rising edge is due on `out_p` just after that same edge. The bench therefore drives inputs on falling edges and compares outputs at the next falling edge. It uses a handshake model that tracks acceptance, stalls and draining.

`in_ready` depends combinationally on `out_ready`. It is compared one time unit after each new drive. The combinational variants show their result within the same cycle, so they are checked one time unit after each operand change. For small N every operand pair is covered.

// File: rtl/mm8_pkg.sv
package mm8_pkg;

  typedef struct packed {
    logic neg;
    logic x1;
    logic x2;
    logic x3;
    logic x4;
  } booth_sel_t;

  function automatic int digits(input int n);
    return (n + 2) / 3;
  endfunction

  function automatic int csa_next(input int c);
    return (c / 3) * 2 + c % 3;
  endfunction

  function automatic int csa_count(input int c, input int lvl);
    int r;
    r = c;
    for (int i = 0; i < lvl; i++) r = csa_next(r);
    return r;
  endfunction

  function automatic int csa_depth(input int c);
    int r;
    int d;
    r = c;
    d = 0;
    while (r > 2) begin
      r = csa_next(r);
      d++;
    end
    return d;
  endfunction

endpackage

// File: rtl/mm8_hard3.sv
// Segmented 3A generator: 3A = A + rot1(A) kept as sum and rotated segment carries.
module mm8_hard3 #(
  parameter int N = 16,
  parameter int K = 4
) (
  input  logic [N-1:0] a,
  output logic [N-1:0] s_o,
  output logic [N-1:0] c_o
);
  localparam int KE   = (K < 1) ? 1 : ((K > N) ? N : K);
  localparam int NSEG = (N + KE - 1) / KE;

  logic [N-1:0]    a2;
  logic [NSEG-1:0] seg_co;

  assign a2 = {a[N-2:0], a[N-1]};

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int LO = s * KE;
    localparam int HI = (((LO + KE) < N) ? (LO + KE) : N) - 1;
    localparam int W  = HI - LO + 1;
    logic [W:0] part;
    assign part        = {1'b0, a[HI:LO]} + {1'b0, a2[HI:LO]};
    assign s_o[HI:LO]  = part[W-1:0];
    assign seg_co[s]   = part[W];
  end

  // each segment carry lands on the first bit of the next segment (wrapping)
  always_comb begin
    c_o = '0;
    for (int s = 0; s < NSEG; s++)
      c_o[((((s + 1) * KE) < N) ? ((s + 1) * KE) : N) % N] = seg_co[s];
  end
endmodule

// File: rtl/mm8_booth_pp.sv
// One radix-8 Booth digit: select, rotate by 3*IDX, complement when negative.
module mm8_booth_pp #(
  parameter int N   = 16,
  parameter int IDX = 0
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] h3_s,
  input  logic [N-1:0] h3_c,
  input  logic [3:0]   win,
  output logic [N-1:0] pp_a,
  output logic [N-1:0] pp_b
);
  import mm8_pkg::*;

  localparam int ROT = (3 * IDX) % N;
  localparam int R1  = 1 % N;
  localparam int R2  = 2 % N;

  function automatic logic [N-1:0] rotl(input logic [N-1:0] x, input int r);
    return (x << r) | (x >> (N - r));
  endfunction

  booth_sel_t   sel;
  logic [2:0]   mag;
  logic [N-1:0] ma;
  logic [N-1:0] mb;

  always_comb begin
    mag     = win[3] ? ~win[2:0] : win[2:0];
    sel.neg = win[3] & ~(&win[2:0]);
    sel.x1  = (mag == 3'd1) || (mag == 3'd2);
    sel.x2  = (mag == 3'd3) || (mag == 3'd4);
    sel.x3  = (mag == 3'd5) || (mag == 3'd6);
    sel.x4  = (mag == 3'd7);
    ma = '0;
    mb = '0;
    if (sel.x1) ma = a;
    if (sel.x2) ma = rotl(a, R1);
    if (sel.x4) ma = rotl(a, R2);
    if (sel.x3) begin
      ma = h3_s;
      mb = h3_c;
    end
    pp_a = rotl(ma, ROT) ^ {N{sel.neg}};
    pp_b = rotl(mb, ROT) ^ {N{sel.neg}};
  end
endmodule

// File: rtl/mm8_csa_eac.sv
// Carry-save tree of 3:2 rows; every row's top carry wraps into bit 0.
module mm8_csa_eac #(
  parameter int N    = 16,
  parameter int NOPS = 12
) (
  input  logic [N-1:0] ops [NOPS],
  output logic [N-1:0] sum_o,
  output logic [N-1:0] carry_o
);
  import mm8_pkg::*;

  localparam int DEP = csa_depth(NOPS);

  logic [N-1:0] lv [DEP+1][NOPS];

  for (genvar t = 0; t < NOPS; t++) begin : g_in
    assign lv[0][t] = ops[t];
  end

  for (genvar l = 0; l < DEP; l++) begin : g_lvl
    localparam int C  = csa_count(NOPS, l);
    localparam int NG = C / 3;
    for (genvar t = 0; t < NOPS; t++) begin : g_slot
      if (t < 2 * NG) begin : g_grp
        if (t % 2 == 0) begin : g_sum
          assign lv[l+1][t] = lv[l][3*(t/2)] ^ lv[l][3*(t/2)+1] ^ lv[l][3*(t/2)+2];
        end else begin : g_cy
          logic [N-1:0] mj;
          assign mj = (lv[l][3*(t/2)] & lv[l][3*(t/2)+1]) |
                      (lv[l][3*(t/2)] & lv[l][3*(t/2)+2]) |
                      (lv[l][3*(t/2)+1] & lv[l][3*(t/2)+2]);
          assign lv[l+1][t] = {mj[N-2:0], mj[N-1]};
        end
      end else if (t < 2 * NG + C % 3) begin : g_pass
        assign lv[l+1][t] = lv[l][3*NG + t - 2*NG];
      end else begin : g_zero
        assign lv[l+1][t] = '0;
      end
    end
  end

  assign sum_o   = lv[DEP][0];
  assign carry_o = lv[DEP][1];
endmodule

// File: rtl/mm8_prefix_eac.sv
// Sklansky prefix adder modulo 2^N-1: the carry out re-enters at bit 0.
module mm8_prefix_eac #(
  parameter int N = 16
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] s
);
  localparam int LV = $clog2(N);

  logic [N-1:0] g [LV+1];
  logic [N-1:0] p [LV+1];
  logic         cout;
  logic [N-1:0] cvec;

  assign g[0] = x & y;
  assign p[0] = x ^ y;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (((i >> l) & 1) == 1) begin : g_op
        localparam int J = ((i >> l) << l) - 1;
        assign g[l+1][i] = g[l][i] | (p[l][i] & g[l][J]);
        assign p[l+1][i] = p[l][i] & p[l][J];
      end else begin : g_cp
        assign g[l+1][i] = g[l][i];
        assign p[l+1][i] = p[l][i];
      end
    end
  end

  assign cout = g[LV][N-1];
  assign cvec = {g[LV][N-2:0] | (p[LV][N-2:0] & {(N-1){cout}}), cout};
  assign s    = p[0] ^ cvec;
endmodule

// File: rtl/mod_mul_booth8.sv
module mod_mul_booth8 #(
  parameter int N       = 16,
  parameter int K       = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_p
);
  import mm8_pkg::*;

  localparam int D    = digits(N);
  localparam int NB   = 3 * D;
  localparam int NOPS = 2 * D;

  logic [NB:0]  bw;
  logic [N-1:0] h3_s;
  logic [N-1:0] h3_c;
  logic [N-1:0] ops [NOPS];
  logic [N-1:0] red_s;
  logic [N-1:0] red_c;
  logic [N-1:0] raw;
  logic [N-1:0] res;

  // padded multiplier; the bit under digit 0 is the top padded bit (cyclic wrap)
  always_comb begin
    bw       = '0;
    bw[N:1]  = in_b;
    bw[0]    = bw[NB];
  end

  mm8_hard3 #(.N(N), .K(K)) i_hard3 (.a(in_a), .s_o(h3_s), .c_o(h3_c));

  for (genvar i = 0; i < D; i++) begin : g_dig
    mm8_booth_pp #(.N(N), .IDX(i)) i_pp (
      .a   (in_a),
      .h3_s(h3_s),
      .h3_c(h3_c),
      .win (bw[3*i+3:3*i]),
      .pp_a(ops[2*i]),
      .pp_b(ops[2*i+1])
    );
  end

  mm8_csa_eac #(.N(N), .NOPS(NOPS)) i_csa (.ops(ops), .sum_o(red_s), .carry_o(red_c));

  mm8_prefix_eac #(.N(N)) i_add (.x(red_s), .y(red_c), .s(raw));

  assign res = (&raw) ? '0 : raw;

  if (OUT_REG) begin : g_reg
    logic         v_q;
    logic [N-1:0] p_q;

    assign in_ready = !v_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        p_q <= '0;
      end else if (in_ready) begin
        v_q <= in_valid;
        if (in_valid) p_q <= res;
      end
    end

    assign out_valid = v_q;
    assign out_p     = p_q;

    p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> {{N{1'b0}}, out_p} ==
        (({{N{1'b0}}, $past(in_a)} * {{N{1'b0}}, $past(in_b)}) % {{N{1'b0}}, {N{1'b1}}}));
    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_p));
    p_ready_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
    p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);
  end else begin : g_comb
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
    assign out_p     = res;

    p_comb_product_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> {{N{1'b0}}, out_p} ==
        (({{N{1'b0}}, in_a} * {{N{1'b0}}, in_b}) % {{N{1'b0}}, {N{1'b1}}}));
  end

  p_no_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_p != {N{1'b1}});
endmodule

// File: tb/test_mod_mul_booth8.sv
module test_mod_mul_booth8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // main: N=16, K=4, registered
  logic m_iv, m_ir, m_ov, m_or;
  logic [15:0] m_a, m_b, m_p;
  // small: N=5, K=2, combinational
  logic s_iv, s_ir, s_ov, s_or;
  logic [4:0] s_a, s_b, s_p;
  // wrap: N=6, K=7, combinational
  logic w_iv, w_ir, w_ov, w_or;
  logic [5:0] w_a, w_b, w_p;

  mod_mul_booth8 #(.N(16), .K(4), .OUT_REG(1'b1)) i_mod_mul_booth8 (
    .clk(clk), .rst_n(rst_n), .in_valid(m_iv), .in_ready(m_ir), .in_a(m_a), .in_b(m_b),
    .out_valid(m_ov), .out_ready(m_or), .out_p(m_p));

  mod_mul_booth8 #(.N(5), .K(2), .OUT_REG(1'b0)) i_mod_mul_booth8_n5 (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_ready(s_ir), .in_a(s_a), .in_b(s_b),
    .out_valid(s_ov), .out_ready(s_or), .out_p(s_p));

  mod_mul_booth8 #(.N(6), .K(7), .OUT_REG(1'b0)) i_mod_mul_booth8_n6 (
    .clk(clk), .rst_n(rst_n), .in_valid(w_iv), .in_ready(w_ir), .in_a(w_a), .in_b(w_b),
    .out_valid(w_ov), .out_ready(w_or), .out_p(w_p));

  function automatic longint unsigned ref_mod(input longint unsigned a, input longint unsigned b,
                                              input int n);
    longint unsigned m;
    m = (64'd1 << n) - 64'd1;
    return (a * b) % m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    report();
  end

  logic [15:0] da [10];
  logic [15:0] db [10];

  initial begin
    logic        mv;
    logic [15:0] md;
    logic        stalled;
    logic        exp_rdy;
    void'($urandom(32'd2024));
    da[0] = 16'hFFFF; db[0] = 16'h1234;
    da[1] = 16'h4321; db[1] = 16'hFFFF;
    da[2] = 16'hFFFF; db[2] = 16'hFFFF;
    da[3] = 16'h0000; db[3] = 16'h0000;
    da[4] = 16'h0001; db[4] = 16'h0001;
    da[5] = 16'hFFFE; db[5] = 16'hFFFE;
    da[6] = 16'h8000; db[6] = 16'h0002;
    da[7] = 16'h5555; db[7] = 16'h0003;
    da[8] = 16'h3333; db[8] = 16'h0005;
    da[9] = 16'h0101; db[9] = 16'h00FF;

    m_iv = 0; m_or = 0; m_a = '0; m_b = '0;
    s_iv = 0; s_or = 0; s_a = '0; s_b = '0;
    w_iv = 0; w_or = 0; w_a = '0; w_b = '0;

    // reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 out_valid in reset", {31'd0, m_ov}, 32'd0);
    check("R7 ready in reset", {31'd0, m_ir}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", {31'd0, m_ov}, 32'd0);

    // stream test on the registered instance
    mv = 1'b0; md = '0; stalled = 1'b0;
    for (int it = 0; it < 3000; it++) begin
      if (it > 0) @(negedge clk);
      check("R5 out_valid", {31'd0, m_ov}, {31'd0, mv});
      if (mv) begin
        if (stalled)        check("R6 held result", {16'd0, m_p}, {16'd0, md});
        else if (md == 0)   check("R2 zero form", {16'd0, m_p}, {16'd0, md});
        else                check("R1 product", {16'd0, m_p}, {16'd0, md});
      end
      if (it < 10) begin
        m_iv = 1'b1; m_or = 1'b1; m_a = da[it]; m_b = db[it];
      end else begin
        m_iv = ($urandom % 4) != 0;
        m_or = ($urandom % 3) != 0;
        case ($urandom % 8)
          0: m_a = 16'hFFFF;
          1: m_a = 16'h0000;
          default: m_a = 16'($urandom);
        endcase
        case ($urandom % 8)
          0: m_b = 16'hFFFF;
          1: m_b = 16'h0001;
          default: m_b = 16'($urandom);
        endcase
      end
      #1;
      exp_rdy = !mv || m_or;
      check("R7 in_ready", {31'd0, m_ir}, {31'd0, exp_rdy});
      if (m_iv && exp_rdy) begin
        mv = 1'b1;
        md = 16'(ref_mod(m_a, m_b, 16));
        stalled = 1'b0;
      end else if (mv && !m_or) begin
        stalled = 1'b1;
      end else if (m_or) begin
        mv = 1'b0;
        stalled = 1'b0;
      end
    end
    @(negedge clk);
    m_iv = 1'b0;

    // exhaustive N=5, K=2 (K does not divide N)
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        logic [31:0] e;
        s_a = 5'(a); s_b = 5'(b);
        s_iv = 1'($urandom); s_or = 1'($urandom);
        #1;
        e = 32'(ref_mod(a, b, 5));
        if (e == 0) check("R2 zero form n5", {27'd0, s_p}, e);
        else        check("R3 product n5", {27'd0, s_p}, e);
        check("R8 pass-through n5", {30'd0, s_ov, s_ir}, {30'd0, s_iv, s_or});
      end
    end

    // exhaustive N=6, K=7 (digit wrap from the top bit)
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        logic [31:0] e;
        w_a = 6'(a); w_b = 6'(b);
        w_iv = 1'($urandom); w_or = 1'($urandom);
        #1;
        e = 32'(ref_mod(a, b, 6));
        if (e == 0) check("R2 zero form n6", {26'd0, w_p}, e);
        else        check("R4 product n6", {26'd0, w_p}, e);
        check("R8 pass-through n6", {30'd0, w_ov, w_ir}, {30'd0, w_iv, w_or});
      end
    end

    report();
  end
endmodule